// File: doc/BRIEF.md
# DC-Balanced Daisy-Chain Byte Serializer

This block sends one byte at a time onto a single-wire daisy-chain link, in a line code with no DC content. Each coded bit goes out as two complementary half-bits. A transmission opens with a high lead-in half-bit. Then come twelve coded bits: two sync zeros, the start-of-frame marker, the eight data bits least significant first, and the byte-error marker. A low closing half-bit ends the transmission. Each byte therefore always takes 26 half-bits. The half-bit length is set in system clock cycles by the `HALF_CYC` parameter (10 cycles gives 250 ns at 40 MHz).

A 3-bit gap selector, captured along with the byte, sets only the idle time that follows the closing half-bit. The block stays busy through that gap. When the gap ends it gives a one-cycle done pulse, and a new byte can be accepted in that same cycle. This gives a fixed byte time and a throughput that depends on the gap setting.

Top module: `stack_byte_encoder`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `line_o` is low. `busy_o` and `done_o` are low after reset.
- R2: `send_i` is accepted only in a cycle where `busy_o` is low. A `send_i` pulse while busy is ignored, and so are changes to `data_i`, `sof_i`, `berr_i` or `gap_sel_i` while busy. The byte in flight and its gap are unchanged, and no extra byte follows.
- R3: In the first `HALF_CYC` cycles after the accepting edge, `line_o` is high (the lead-in half-bit).
- R4: Each coded bit takes two half-bits of `HALF_CYC` cycles each. A 0 is sent low then high, and a 1 is sent high then low.
- R5: The coded bits go out in the order 0, 0, `sof_i`, `data_i[0]` through `data_i[7]`, `berr_i`. These are the values captured at acceptance.
- R6: Half-bit 25 (the closing half-bit) is low.
- R7: Line activity lasts exactly 26*`HALF_CYC` cycles for every gap setting.
- R8: After the closing half-bit, `line_o` stays low and `busy_o` stays high for (`gap_sel_i`+1)*`GAP_UNIT` cycles. The `gap_sel_i` value used is the one captured at acceptance.
- R9: `done_o` is high for exactly one cycle, in the first cycle after the gap. `busy_o` is low in that cycle, and a `send_i` in that cycle is accepted.
- R10: Within each byte, `line_o` is high for exactly 13*`HALF_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Request to send the presented byte |
| data_i | input | 8 | Byte payload |
| sof_i | input | 1 | Start-of-frame marker for this byte |
| berr_i | input | 1 | Byte-error marker for this byte |
| gap_sel_i | input | GAP_W | Inter-byte gap selector |
| line_o | output | 1 | Encoded line level |
| busy_o | output | 1 | Byte or gap in progress |
| done_o | output | 1 | One-cycle pulse when the gap has finished |

## Verification
The bench targets bytes whose bit values put the complement pairs next to each other, such as all ones, all zeros and alternating patterns, with the start and error markers set separately. A swapped half-bit polarity or a data order reversed to MSB first shows up as a per-cycle line mismatch. The smallest and largest gap settings, sent back to back, expose an off-by-one in the gap counter and a design that lets the gap setting stretch the byte itself. A send pulse with new data and a new gap setting arrives in the middle of a byte. This catches a design that restarts the byte, re-captures the fields, or re-reads the gap selector live.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

  localparam int unsigned NUM_HALVES = 26;
  localparam int unsigned LAST_HALF  = NUM_HALVES - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_GAP  = 2'd2
  } enc_state_e;

  // Coded bit vector, index 0 leaves the wire first.
  function automatic logic [11:0] build_frame(input logic [7:0] data,
                                              input logic sof,
                                              input logic berr);
    return {berr, data, sof, 2'b00};
  endfunction

  // Wire level for one half-bit slot of the 26-slot byte.
  function automatic logic half_level(input logic [4:0] idx,
                                      input logic [11:0] frame);
    logic [4:0] slot;
    if (idx == 5'd0) return 1'b1;
    if (idx >= 5'(LAST_HALF)) return 1'b0;
    slot = idx - 5'd1;
    return frame[slot[4:1]] ^ slot[0];
  endfunction

  function automatic int unsigned gap_cycles(input int unsigned sel,
                                             input int unsigned unit);
    return (sel + 1) * unit;
  endfunction

endpackage

// File: rtl/sbe_half_timer.sv
module sbe_half_timer #(
  parameter int unsigned HALF_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run,
  output logic [4:0] half_idx,
  output logic       half_end,
  output logic       frame_end
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign half_end  = run && (cnt == CNT_LAST);
  assign frame_end = half_end && (half_idx == 5'(sbe_pkg::LAST_HALF));

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      cnt      <= '0;
      half_idx <= '0;
    end else if (run) begin
      if (half_end) begin
        cnt      <= '0;
        half_idx <= frame_end ? 5'd0 : half_idx + 5'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> half_idx <= 5'(sbe_pkg::LAST_HALF));

  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !frame_end && !start) |=> half_idx == $past(half_idx) + 5'd1);

endmodule

// File: rtl/sbe_gap_timer.sv
module sbe_gap_timer #(
  parameter int unsigned GAP_W    = 3,
  parameter int unsigned GAP_UNIT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [GAP_W-1:0] sel,
  output logic             gap_end
);
  localparam int unsigned MAX_GAP = (2 ** GAP_W) * GAP_UNIT;
  localparam int unsigned GCW     = $clog2(MAX_GAP + 1);

  logic [GCW-1:0] cnt;
  logic [GCW-1:0] limit;

  assign limit   = GCW'(sbe_pkg::gap_cycles(int'(sel), GAP_UNIT));
  assign gap_end = run && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  cnt <= '0;
    else if (run)         cnt <= cnt + 1'b1;
  end

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < limit);

endmodule

// File: rtl/sbe_line_coder.sv
module sbe_line_coder (
  input  logic        active,
  input  logic [4:0]  half_idx,
  input  logic [11:0] frame,
  output logic        line
);
  always_comb line = active ? sbe_pkg::half_level(half_idx, frame) : 1'b0;
endmodule

// File: rtl/stack_byte_encoder.sv
module stack_byte_encoder #(
  parameter int unsigned HALF_CYC = 10,
  parameter int unsigned GAP_W    = 3,
  parameter int unsigned GAP_UNIT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             send_i,
  input  logic [7:0]       data_i,
  input  logic             sof_i,
  input  logic             berr_i,
  input  logic [GAP_W-1:0] gap_sel_i,
  output logic             line_o,
  output logic             busy_o,
  output logic             done_o
);
  import sbe_pkg::*;

  localparam int unsigned HCW = $clog2(NUM_HALVES * HALF_CYC + 1);
  localparam logic [HCW-1:0] HIGH_TARGET = HCW'((NUM_HALVES / 2) * HALF_CYC);

  enc_state_e       state;
  logic [11:0]      cap_frame;
  logic [GAP_W-1:0] cap_sel;
  logic [HCW-1:0]   hi_cnt;

  // Named events for the assertions.
  logic       accept;
  logic       tx_run;
  logic       gap_run;
  logic [4:0] half_idx;
  logic       half_end;
  logic       frame_end;
  logic       gap_end;

  assign accept  = send_i && (state == ST_IDLE);
  assign tx_run  = (state == ST_TX);
  assign gap_run = (state == ST_GAP);
  assign busy_o  = (state != ST_IDLE);

  sbe_half_timer #(.HALF_CYC(HALF_CYC)) u_half (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(tx_run),
    .half_idx(half_idx), .half_end(half_end), .frame_end(frame_end)
  );

  sbe_gap_timer #(.GAP_W(GAP_W), .GAP_UNIT(GAP_UNIT)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear(frame_end), .run(gap_run),
    .sel(cap_sel), .gap_end(gap_end)
  );

  sbe_line_coder u_coder (
    .active(tx_run), .half_idx(half_idx), .frame(cap_frame), .line(line_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_frame <= '0;
      cap_sel   <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_TX;
          cap_frame <= build_frame(data_i, sof_i, berr_i);
          cap_sel   <= gap_sel_i;
        end
        ST_TX:  if (frame_end) state <= ST_GAP;
        ST_GAP: if (gap_end) begin
          state  <= ST_IDLE;
          done_o <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // High-time accumulator, used only by the balance check.
  always_ff @(posedge clk) begin
    if (!rst_n || accept)      hi_cnt <= '0;
    else if (tx_run && line_o) hi_cnt <= hi_cnt + 1'b1;
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !line_o);

  a_r2_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(cap_frame) && $stable(cap_sel)));

  a_r3_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> line_o);

  a_r6_postamble: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !line_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_free: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r10_balance: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> hi_cnt == HIGH_TARGET);

endmodule

// File: tb/stack_byte_encoder_tb.sv
module stack_byte_encoder_tb;
  localparam int HALF = 10;
  localparam int GW   = 3;
  localparam int UNIT = 20;

  typedef struct {
    logic [7:0] data;
    logic       sof;
    logic       berr;
    int         gap;
  } item_t;

  logic clk = 0, rst_n = 0, send = 0, sof = 0, berr = 0;
  logic [7:0] data = 0;
  logic [GW-1:0] gsel = 0;
  logic line, busy, done;

  int tests = 0, fails = 0, pushed = 0, checked = 0;
  item_t q[$];

  always #5 clk = ~clk;

  stack_byte_encoder #(.HALF_CYC(HALF), .GAP_W(GW), .GAP_UNIT(UNIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .send_i(send), .data_i(data), .sof_i(sof),
    .berr_i(berr), .gap_sel_i(gsel), .line_o(line), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Expected bit for coded position b, written per position.
  function automatic logic exp_bit(item_t it, int b);
    if (b < 2) return 1'b0;
    if (b == 2) return it.sof;
    if (b == 11) return it.berr;
    return it.data[b - 3];
  endfunction

  function automatic logic exp_level(item_t it, int k);
    int h = k / HALF;
    logic v;
    if (h == 0) return 1'b1;
    if (h == 25) return 1'b0;
    v = exp_bit(it, (h - 1) / 2);
    return ((h - 1) % 2 == 0) ? v : ~v;
  endfunction

  task automatic send_byte(input logic [7:0] d, input logic s, input logic e,
                           input int g);
    item_t it;
    while (busy) @(negedge clk);
    data = d; sof = s; berr = e; gsel = GW'(g); send = 1;
    it.data = d; it.sof = s; it.berr = e; it.gap = (g + 1) * UNIT;
    q.push_back(it); pushed++;
    @(negedge clk);
    send = 0;
  endtask

  // Monitor: per-cycle comparison against the queued expectation.
  initial begin
    item_t it;
    string tag;
    forever begin
      @(negedge clk);
      if (busy) begin
        if (q.size() == 0) begin
          check("R2 unexpected byte", 1, 0);
        end else begin
          it = q.pop_front();
          for (int k = 0; k <= 26 * HALF + it.gap; k++) begin
            if (k > 0) @(negedge clk);
            if (k < 26 * HALF) begin
              if (k < HALF) tag = "R3 lead-in";
              else if (k >= 25 * HALF) tag = "R6 closing";
              else tag = "R4,R5 coded bit";
              check(tag, line, exp_level(it, k));
              check("R7 busy during byte", busy, 1);
            end else if (k < 26 * HALF + it.gap) begin
              tag = (k == 26 * HALF) ? "R7 byte end" : "R8 gap";
              check({tag, " line"}, line, 0);
              check({tag, " busy"}, busy, 1);
              check("R9 no early done", done, 0);
            end else begin
              check("R9 done pulse", done, 1);
              check("R9 busy released", busy, 0);
            end
          end
          checked++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset line", line, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset done", done, 0);

    // Assorted patterns, back to back, smallest and largest gaps.
    send_byte(8'hFF, 1'b1, 1'b0, 0);
    send_byte(8'h00, 1'b0, 1'b1, 7);
    send_byte(8'hA5, 1'b0, 1'b0, 0);
    send_byte(8'h5A, 1'b1, 1'b1, 3);
    send_byte(8'h01, 1'b0, 1'b0, 1);

    // R2: mid-byte send with new fields and a new gap selector is ignored.
    send_byte(8'h80, 1'b0, 1'b0, 0);
    repeat (40) @(negedge clk);
    data = 8'h3C; sof = 1; berr = 1; gsel = 3'd7; send = 1;
    @(negedge clk);
    send = 0;
    while (!done) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R2 no extra byte after ignored send", busy, 0);
    check("R1 idle line", line, 0);

    // R10: count high cycles of one byte at the port.
    send_byte(8'h6E, 1'b1, 1'b0, 0);
    hi = (line === 1'b1) ? 1 : 0;
    for (int k = 1; k < 26 * HALF; k++) begin
      @(negedge clk);
      if (line === 1'b1) hi++;
    end
    check("R10 high cycles per byte", hi, 13 * HALF);

    while (checked != pushed) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9 done cleared", done, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule